// File: doc/BRIEF.md
# Flash Page Mapping Table Loader

This block is a command engine that fills the page translation tables used to reach external flash. Each processor has its own table. A caller hands over one request: a processor select, a process identifier, a virtual base address, a physical base address, a page size in kilobytes and a page count. The engine checks the request against a fixed list of rules. If any rule fails, it returns a numbered status and leaves both tables unchanged. If all rules pass, it writes one table entry per clock cycle until the whole run of pages is stored.

While a burst of writes is in progress, the engine holds a stall output high. This keeps the other processor from fetching through a table that is only partly updated. The engine accepts no new request until the burst ends. It then drops the stall and reports the result with a one-cycle done pulse.

A registered read port lets the surrounding logic, or a bench, see what was written. Pages are 64 KB. Each table has 2^IDX_W entries, and together they cover a virtual window whose upper address bits are fixed by a parameter.

Top module: `flash_map_loader`

## Requirements
- R1: If bits [15:0] of the virtual base or of the physical base are nonzero, the status is 1 and no table entry changes.
- R2: A process identifier above 7 gives status 2.
- R3: A page size value other than 64 gives status 3.
- R4: The start index is virtual address bits [21:16]. If the start index plus the page count is above 64, the status is 4. A run that ends exactly at entry 63 is accepted.
- R5: If virtual address bits [31:22] differ from those of the window base 0x3F40_0000, the status is 5.
- R6: When several rules fail, only the first failing rule in this order is reported: alignment (1), identifier (2), page size (3), table range (4), virtual window (5).
- R7: A request that passes all rules returns status 0. It writes entry start+i of the selected processor's table for each i below the count. The entry value is {pid[2:0], (paddr[23:16]+i) mod 256}, with the identifier in bits [10:8]. The other processor's table is left unchanged.
- R8: For a passing request with count N>0, stall is high for exactly N cycles, starting the cycle after acceptance. Done rises in the cycle stall falls.
- R9: req_ready is low for the whole time stall is high. A request held valid during a burst is accepted once the burst ends. A failing request, or a passing request with count 0, gives done one cycle after acceptance without raising stall.
- R10: rd_data shows the entry addressed by rd_cpu and rd_idx one clock after they are applied.
- R11: After reset, req_ready is 1, and stall and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine can take a request |
| req_cpu | input | 1 | Target table select |
| req_pid | input | 4 | Process identifier |
| req_vaddr | input | 32 | Virtual base address |
| req_paddr | input | 24 | Physical base address in flash |
| req_psize | input | 8 | Page size in KB |
| req_count | input | 7 | Number of pages |
| done | output | 1 | One-cycle result strobe |
| status | output | 3 | Result code, valid with done |
| stall | output | 1 | Stall request to the other processor |
| rd_cpu | input | 1 | Read port table select |
| rd_idx | input | 6 | Read port entry index |
| rd_data | output | 11 | Entry read, one cycle latency |

## Verification
Two situations are hard to reach from the ports. The first is a request that breaks several rules at once, where only the highest-priority code may come back. The vector table builds such requests on purpose: each combines a violation with other violations of lower rank. The second is a request that arrives while a burst is still running. A directed test holds a second, failing request valid from the first cycle of a burst. It checks that the request is taken only after done and that its result follows one cycle later. Every test that is meant to change nothing aims at entries that earlier requests already filled, and a final sweep of both tables reads them back.

// File: rtl/flm_pkg.sv
package flm_pkg;

  typedef enum logic [2:0] {
    ST_OK     = 3'd0,
    ST_ALIGN  = 3'd1,
    ST_PID    = 3'd2,
    ST_PSIZE  = 3'd3,
    ST_TABLE  = 3'd4,
    ST_VRANGE = 3'd5
  } flm_status_e;

endpackage

// File: rtl/flm_req_check.sv
module flm_req_check
  import flm_pkg::*;
#(
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 24,
  parameter int PID_W      = 4,
  parameter int PSIZE_W    = 8,
  parameter int CNT_W      = 7,
  parameter int IDX_W      = 6,
  parameter int PAGE_SHIFT = 16,
  parameter int PAGE_KB    = 64,
  parameter int MAX_PID    = 7,
  parameter logic [VADDR_W-1:0] VWIN_BASE = 32'h3F40_0000
) (
  input  logic [VADDR_W-1:0] vaddr_i,
  input  logic [PADDR_W-1:0] paddr_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic [PSIZE_W-1:0] psize_i,
  input  logic [CNT_W-1:0]   count_i,
  output flm_status_e        status_o,
  output logic [IDX_W-1:0]   idx_o
);

  localparam int WIN_LSB = PAGE_SHIFT + IDX_W;
  localparam logic [CNT_W:0] DEPTH = (CNT_W+1)'(1 << IDX_W);

  logic misaligned, pid_bad, psize_bad, table_bad, window_bad;
  logic [CNT_W:0] run_end;

  always_comb begin
    idx_o      = vaddr_i[PAGE_SHIFT +: IDX_W];
    misaligned = (|vaddr_i[PAGE_SHIFT-1:0]) | (|paddr_i[PAGE_SHIFT-1:0]);
    pid_bad    = pid_i > PID_W'(MAX_PID);
    psize_bad  = psize_i != PSIZE_W'(PAGE_KB);
    run_end    = (CNT_W+1)'(idx_o) + (CNT_W+1)'(count_i);
    table_bad  = run_end > DEPTH;
    window_bad = vaddr_i[VADDR_W-1:WIN_LSB] != VWIN_BASE[VADDR_W-1:WIN_LSB];

    if (misaligned)      status_o = ST_ALIGN;
    else if (pid_bad)    status_o = ST_PID;
    else if (psize_bad)  status_o = ST_PSIZE;
    else if (table_bad)  status_o = ST_TABLE;
    else if (window_bad) status_o = ST_VRANGE;
    else                 status_o = ST_OK;
  end

endmodule

// File: rtl/flm_burst_seq.sv
module flm_burst_seq
  import flm_pkg::*;
#(
  parameter int CPU_W  = 1,
  parameter int IDX_W  = 6,
  parameter int PPN_W  = 8,
  parameter int TAG_W  = 3,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept_i,
  input  flm_status_e       check_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [CPU_W-1:0]  cpu_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              busy_o,
  output logic              done_o,
  output flm_status_e       status_o,
  output logic              wr_en_o,
  output logic [CPU_W-1:0]  wr_cpu_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W+PPN_W-1:0] wr_data_o
);

  logic              busy_q, done_q;
  flm_status_e       status_q;
  logic [CNT_W-1:0]  left_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PPN_W-1:0]  ppn_q;
  logic [TAG_W-1:0]  tag_q;
  logic [CPU_W-1:0]  cpu_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      status_q <= ST_OK;
      left_q   <= '0;
      idx_q    <= '0;
      ppn_q    <= '0;
      tag_q    <= '0;
      cpu_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        idx_q  <= idx_q + 1'b1;
        ppn_q  <= ppn_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          status_q <= ST_OK;
        end
      end else if (accept_i) begin
        if (check_i != ST_OK || count_i == '0) begin
          done_q   <= 1'b1;
          status_q <= check_i;
        end else begin
          busy_q <= 1'b1;
          left_q <= count_i;
          idx_q  <= idx_i;
          ppn_q  <= ppn_i;
          tag_q  <= tag_i;
          cpu_q  <= cpu_i;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign status_o  = status_q;
  assign wr_en_o   = busy_q;
  assign wr_cpu_o  = cpu_q;
  assign wr_idx_o  = idx_q;
  assign wr_data_o = {tag_q, ppn_q};

  // R8: last write of a burst ends the stall and raises done
  a_r8_burst_end: assert property (@(posedge clk) disable iff (rst)
    (busy_q && left_q == CNT_W'(1)) |=> (!busy_q && done_q));
  // R9: no result strobe while entries are still being written
  a_r9_no_done_busy: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !done_q);
  // R7: consecutive writes walk consecutive entries and pages
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |->
      (idx_q == $past(idx_q) + 1'b1 && ppn_q == $past(ppn_q) + 1'b1));

endmodule

// File: rtl/flm_table.sv
module flm_table #(
  parameter int IDX_W   = 6,
  parameter int ENTRY_W = 11
) (
  input  logic               clk,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  logic [ENTRY_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output logic [ENTRY_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/flash_map_loader.sv
module flash_map_loader
  import flm_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 24,
  parameter int PID_W      = 4,
  parameter int PSIZE_W    = 8,
  parameter int IDX_W      = 6,
  parameter int PAGE_SHIFT = 16,
  parameter int PAGE_KB    = 64,
  parameter int MAX_PID    = 7,
  parameter logic [31:0] VWIN_BASE = 32'h3F40_0000,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int CNT_W   = IDX_W + 1,
  localparam int PPN_W   = PADDR_W - PAGE_SHIFT,
  localparam int TAG_W   = $clog2(MAX_PID + 1),
  localparam int ENTRY_W = TAG_W + PPN_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CPU_W-1:0]   req_cpu,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [VADDR_W-1:0] req_vaddr,
  input  logic [PADDR_W-1:0] req_paddr,
  input  logic [PSIZE_W-1:0] req_psize,
  input  logic [CNT_W-1:0]   req_count,
  output logic               done,
  output logic [2:0]         status,
  output logic               stall,
  input  logic [CPU_W-1:0]   rd_cpu,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);

  flm_status_e        check_st, seq_st;
  logic [IDX_W-1:0]   start_idx;
  logic               busy, accept;
  logic               wr_en;
  logic [CPU_W-1:0]   wr_cpu;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRY_W-1:0] wr_data;
  logic [CPU_W-1:0]   rd_cpu_q;
  logic [ENTRY_W-1:0] tbl_rdata [NUM_CPU];

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  flm_req_check #(
    .VADDR_W(VADDR_W), .PADDR_W(PADDR_W), .PID_W(PID_W), .PSIZE_W(PSIZE_W),
    .CNT_W(CNT_W), .IDX_W(IDX_W), .PAGE_SHIFT(PAGE_SHIFT), .PAGE_KB(PAGE_KB),
    .MAX_PID(MAX_PID), .VWIN_BASE(VADDR_W'(VWIN_BASE))
  ) u_check (
    .vaddr_i(req_vaddr), .paddr_i(req_paddr), .pid_i(req_pid),
    .psize_i(req_psize), .count_i(req_count),
    .status_o(check_st), .idx_o(start_idx)
  );

  flm_burst_seq #(
    .CPU_W(CPU_W), .IDX_W(IDX_W), .PPN_W(PPN_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .accept_i(accept), .check_i(check_st),
    .idx_i(start_idx), .ppn_i(req_paddr[PADDR_W-1:PAGE_SHIFT]),
    .tag_i(req_pid[TAG_W-1:0]), .cpu_i(req_cpu), .count_i(req_count),
    .busy_o(busy), .done_o(done), .status_o(seq_st),
    .wr_en_o(wr_en), .wr_cpu_o(wr_cpu), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_tbl
    flm_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_tbl (
      .clk(clk),
      .we_i(wr_en && wr_cpu == CPU_W'(g)),
      .waddr_i(wr_idx), .wdata_i(wr_data),
      .raddr_i(rd_idx), .rdata_o(tbl_rdata[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_cpu_q <= '0;
    else     rd_cpu_q <= rd_cpu;
  end

  assign rd_data = tbl_rdata[rd_cpu_q];
  assign status  = seq_st;
  assign stall   = busy;

  // R9: the request channel is closed during a write burst
  a_r9_ready_low: assert property (@(posedge clk) disable iff (rst)
    stall |-> !req_ready);
  // R1: a rejected request never starts a burst
  a_r1_reject_no_write: assert property (@(posedge clk) disable iff (rst)
    (accept && check_st != ST_OK) |=> (!stall && done && status != 3'd0));
  // R8: stall only falls together with a done strobe
  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> done);
  // R6: a reported error code is one of the defined values
  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    done |-> status <= 3'd5);

endmodule

// File: tb/test_flash_map_loader.sv
module test_flash_map_loader;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic        cpu;
    logic [3:0]  pid;
    logic [31:0] va;
    logic [23:0] pa;
    logic [7:0]  ps;
    logic [6:0]  cnt;
    logic [2:0]  st;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd3, 32'h3F40_0000, 24'h12_0000, 8'd64, 7'd4,  3'd0}, // R7 basic
    '{1'b1, 4'd5, 32'h3F45_0000, 24'hFE_0000, 8'd64, 7'd3,  3'd0}, // R7 ppn wrap
    '{1'b0, 4'd1, 32'h3F40_8000, 24'h33_0000, 8'd64, 7'd2,  3'd1}, // R1 vaddr
    '{1'b0, 4'd1, 32'h3F40_0000, 24'h33_1000, 8'd64, 7'd2,  3'd1}, // R1 paddr
    '{1'b0, 4'd8, 32'h3F40_0000, 24'h33_0000, 8'd64, 7'd2,  3'd2}, // R2 pid 8
    '{1'b0, 4'd2, 32'h3F40_0000, 24'h33_0000, 8'd32, 7'd2,  3'd3}, // R3
    '{1'b0, 4'd2, 32'h3F7E_0000, 24'h33_0000, 8'd64, 7'd3,  3'd4}, // R4 over
    '{1'b0, 4'd6, 32'h3F7E_0000, 24'h40_0000, 8'd64, 7'd2,  3'd0}, // R4 exact end
    '{1'b0, 4'd2, 32'h4000_0000, 24'h33_0000, 8'd64, 7'd1,  3'd5}, // R5
    '{1'b0, 4'd9, 32'h3F40_8000, 24'h33_0000, 8'd32, 7'd1,  3'd1}, // R6 1 wins
    '{1'b0, 4'd9, 32'h3F7F_0000, 24'h33_0000, 8'd16, 7'd9,  3'd2}, // R6 2 wins
    '{1'b0, 4'd2, 32'h4000_0000, 24'h33_0000, 8'd0,  7'd1,  3'd3}, // R6 3 wins
    '{1'b0, 4'd2, 32'h4030_0000, 24'h33_0000, 8'd64, 7'd20, 3'd4}, // R6 4 wins
    '{1'b0, 4'd2, 32'h3F40_0000, 24'h33_0000, 8'd64, 7'd0,  3'd0}, // R9 count 0
    '{1'b1, 4'd7, 32'h3F40_0000, 24'h80_0000, 8'd64, 7'd64, 3'd0}, // R7 full
    '{1'b0, 4'd2, 32'h3F40_0000, 24'h33_0000, 8'd64, 7'd65, 3'd4}  // R4 count 65
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_cpu = 1'b0;
  logic [3:0]  req_pid = '0;
  logic [31:0] req_vaddr = '0;
  logic [23:0] req_paddr = '0;
  logic [7:0]  req_psize = '0;
  logic [6:0]  req_count = '0;
  logic        done;
  logic [2:0]  status;
  logic        stall;
  logic        rd_cpu = 1'b0;
  logic [5:0]  rd_idx = '0;
  logic [10:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [10:0] shadow [2][64];
  bit          known  [2][64];

  flash_map_loader i_flash_map_loader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_cpu(req_cpu), .req_pid(req_pid), .req_vaddr(req_vaddr),
    .req_paddr(req_paddr), .req_psize(req_psize), .req_count(req_count),
    .done(done), .status(status), .stall(stall),
    .rd_cpu(rd_cpu), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic c, input logic [5:0] i, output logic [10:0] d);
    @(negedge clk);
    rd_cpu = c;
    rd_idx = i;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic drive(input vec_t v);
    req_cpu   = v.cpu;
    req_pid   = v.pid;
    req_vaddr = v.va;
    req_paddr = v.pa;
    req_psize = v.ps;
    req_count = v.cnt;
  endtask

  // waits for done after the accepting edge; returns stall cycles seen
  task automatic wait_done(output int stalls, output logic [2:0] st);
    int guard = 0;
    stalls = 0;
    while (!done && guard < 200) begin
      if (stall) stalls++;
      if (stall && req_ready) chk("R9 ready during stall", 1, 0);
      @(negedge clk);
      guard++;
    end
    st = status;
    if (!done) chk("R9 done seen", 0, 1);
  endtask

  task automatic run_vec(input vec_t v);
    int stalls;
    logic [2:0] st;
    logic [10:0] d;
    @(negedge clk);
    drive(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(stalls, st);
    chk("R1-R6 status", int'(st), int'(v.st));
    chk("R8 stall cycles", stalls, (v.st == 3'd0) ? int'(v.cnt) : 0);
    @(negedge clk);
    chk("R9 done is a pulse", int'(done), 0);
    if (v.st == 3'd0) begin
      for (int i = 0; i < int'(v.cnt); i++) begin
        logic [5:0] ix;
        ix = v.va[21:16] + 6'(i);
        shadow[v.cpu][ix] = {v.pid[2:0], 8'(v.pa[23:16] + 8'(i))};
        known[v.cpu][ix]  = 1'b1;
      end
      for (int i = 0; i < int'(v.cnt); i++) begin
        logic [5:0] ix;
        ix = v.va[21:16] + 6'(i);
        rd(v.cpu, ix, d);
        chk("R7 R10 entry", int'(d), int'(shadow[v.cpu][ix]));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int stalls;
    logic [2:0] st;
    logic [10:0] d;
    vec_t a, b;
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 64; i++) known[c][i] = 1'b0;

    repeat (3) @(negedge clk);
    chk("R11 ready in reset", int'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready", int'(req_ready), 1);
    chk("R11 stall", int'(stall), 0);
    chk("R11 done", int'(done), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R9: request held valid from the first cycle of a burst
    a = '{1'b0, 4'd4, 32'h3F50_0000, 24'h55_0000, 8'd64, 7'd3, 3'd0};
    b = '{1'b0, 4'd4, 32'h3F50_0000, 24'h66_0000, 8'd8,  7'd3, 3'd3};
    @(negedge clk);
    drive(a);
    req_valid = 1'b1;
    @(negedge clk);
    drive(b);
    wait_done(stalls, st);
    chk("R9 first result", int'(st), 0);
    chk("R9 first stall length", stalls, 3);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 queued request done", int'(done), 1);
    chk("R9 queued request status", int'(status), 3);
    chk("R9 queued request no stall", int'(stall), 0);
    for (int i = 0; i < 3; i++) begin
      shadow[0][16+i] = {3'd4, 8'(8'h55 + 8'(i))};
      known[0][16+i]  = 1'b1;
    end

    // R1 R7: sweep both tables; rejected requests and the other table left intact
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 64; i++)
        if (known[c][i]) begin
          rd(c[0], 6'(i), d);
          chk("R1 R7 table sweep", int'(d), int'(shadow[c][i]));
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule